// File: doc/BRIEF.md
# DMA Major Loop Iteration Counter

This block keeps the outer-loop iteration state for each channel of a multi-channel DMA engine. Every channel holds a programmed beginning count and a running current count. The channel's minor-loop engine sends a pulse each time it finishes one minor loop. On each pulse the current count moves one step down. When the count runs out, it is refilled from the beginning count, ready for the next major pass.

Two sticky event flags are kept per channel, and each has its own enable. One marks the exact midpoint of the pass and the other marks the end of the pass. Software clears either flag by writing one to it. Software can also request service for a channel by setting a start bit. The start bit drives the channel's service-request output. It drops by itself when the engine reports that the channel has started executing. Address generation is not part of this block.

Top module: `dml_major_loop`

## Requirements
- R1: After reset every channel has beginning count 0 and current count 1, and every flag, enable and service request is low.
- R2: A configuration write to a channel loads the beginning count from `cfg_iter`. It loads the current count with the same value, except that 0 becomes 1. It also stores both interrupt enables. A step pulse to that channel in the same cycle is ignored.
- R3: A step pulse (`minor_done[c]`) that does not empty the count lowers the current count by exactly one, visible on `citer_o` from the next cycle.
- R4: A step pulse that brings the count to zero instead reloads it in the same update with the effective beginning count (a beginning count of 0 acts as 1), so `citer_o` never shows 0.
- R5: When the end enable is set, the step pulse that empties the count sets `done_irq[c]`.
- R6: When the midpoint enable is set, the step pulse that makes the count equal to the effective beginning count shifted right by one sets `half_irq[c]`, once per pass.
- R7: `half_irq[c]` is never set for a beginning count below two.
- R8: Both flags stay set until a write of one to `half_clr[c]` / `done_clr[c]`. A set event in the same cycle as a clear leaves the flag set.
- R9: `sw_start_we` with `sw_start_ch` raises `svc_req` of that channel on the next cycle. `ch_active[c]` drops it, unless a new start write to the same channel arrives in the same cycle, in which case it stays high.
- R10: Channels are independent: a pulse, write or clear aimed at one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel targeted by the configuration write |
| cfg_iter | input | CNT_W | Beginning iteration count to load |
| cfg_half_en | input | 1 | Midpoint interrupt enable to load |
| cfg_done_en | input | 1 | End-of-pass interrupt enable to load |
| sw_start_we | input | 1 | Software start strobe |
| sw_start_ch | input | CH_W | Channel targeted by the start strobe |
| minor_done | input | NUM_CH | Per-channel minor-loop-complete pulse |
| ch_active | input | NUM_CH | Per-channel pulse: execution has begun |
| half_clr | input | NUM_CH | Write-one-to-clear for midpoint flags |
| done_clr | input | NUM_CH | Write-one-to-clear for end flags |
| citer_o | output | NUM_CH*CNT_W | Current counts, channel c at bits [c*CNT_W +: CNT_W] |
| svc_req | output | NUM_CH | Software service request per channel |
| half_irq | output | NUM_CH | Sticky midpoint flags |
| done_irq | output | NUM_CH | Sticky end-of-pass flags |

## Verification
The bench checks beginning counts of 0, 1 and 2. With a 0, a design that did not treat it as 1 would show a zero count or wrap to the maximum. With a 1, a design missing the lower bound would fire the midpoint flag. With a 2, the midpoint and the end are adjacent steps. Odd counts check that the midpoint rounds down and fires once, not again after the reload. A design that let clear beat set would lose an event. Collisions are driven on purpose: a set with a clear, a start with an activation, and a write with a step. A long random mix across all channels looks for cross-channel leakage.

// File: rtl/dml_pkg.sv
package dml_pkg;

  // Per-channel events produced by one step of the counter.
  typedef struct packed {
    logic half_hit;
    logic major_hit;
  } iter_evt_t;

  localparam int DML_NUM_CH_DEF = 4;
  localparam int DML_CNT_W_DEF  = 15;

endpackage

// File: rtl/dml_iter_cnt.sv
module dml_iter_cnt
  import dml_pkg::*;
#(
  parameter int CNT_W = DML_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_hen,
  input  logic             load_den,
  input  logic             step,
  output logic [CNT_W-1:0] citer,
  output iter_evt_t        evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  // Arithmetic kept in functions so the rules are readable in one place.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] b);
    return (b == '0) ? ONE : b;
  endfunction

  function automatic logic [CNT_W-1:0] midpoint(input logic [CNT_W-1:0] e);
    return e >> 1;
  endfunction

  function automatic logic midpoint_allowed(input logic [CNT_W-1:0] e);
    return e >= TWO;
  endfunction

  logic [CNT_W-1:0] biter_q;
  logic [CNT_W-1:0] citer_q;
  logic             hen_q;
  logic             den_q;

  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] nxt;
  logic             step_take;
  logic             wrap_evt;
  logic             mid_evt;

  assign eff       = eff_count(biter_q);
  assign nxt       = citer_q - ONE;
  assign step_take = step && !load;
  assign wrap_evt  = step_take && (nxt == '0);
  assign mid_evt   = step_take && midpoint_allowed(eff) && (nxt == midpoint(eff));

  assign evt.major_hit = wrap_evt && den_q;
  assign evt.half_hit  = mid_evt && hen_q;
  assign citer         = citer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      biter_q <= '0;
      citer_q <= ONE;
      hen_q   <= 1'b0;
      den_q   <= 1'b0;
    end else if (load) begin
      biter_q <= load_val;
      citer_q <= eff_count(load_val);
      hen_q   <= load_hen;
      den_q   <= load_den;
    end else if (step) begin
      citer_q <= wrap_evt ? eff : nxt;
    end
  end

  p_citer_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    citer_q != '0);

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && !wrap_evt) |=> (citer_q == $past(citer_q) - ONE));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (citer_q == $past(eff)));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (biter_q == $past(load_val) && citer_q != '0));

  p_half_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.half_hit |-> (biter_q >= TWO));

  p_half_not_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mid_evt && wrap_evt));

endmodule

// File: rtl/dml_w1c_flag.sv
module dml_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= 1'b0;
    else if (set) q_r <= 1'b1;
    else if (clr) q_r <= 1'b0;
  end

  assign q = q_r;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q_r);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r && !clr) |=> q_r);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q_r);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_r && !set) |=> !q_r);

endmodule

// File: rtl/dml_start_bit.sv
module dml_start_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic begin_exec,
  output logic req
);

  logic req_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          req_r <= 1'b0;
    else if (sw_set)     req_r <= 1'b1;
    else if (begin_exec) req_r <= 1'b0;
  end

  assign req = req_r;

  p_start_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> req_r);

  p_hw_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_exec && !sw_set) |=> !req_r);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!begin_exec && !sw_set) |=> (req_r == $past(req_r)));

endmodule

// File: rtl/dml_major_loop.sv
module dml_major_loop
  import dml_pkg::*;
#(
  parameter int NUM_CH = DML_NUM_CH_DEF,
  parameter int CNT_W  = DML_CNT_W_DEF,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic [CNT_W-1:0]        cfg_iter,
  input  logic                    cfg_half_en,
  input  logic                    cfg_done_en,
  input  logic                    sw_start_we,
  input  logic [CH_W-1:0]         sw_start_ch,
  input  logic [NUM_CH-1:0]       minor_done,
  input  logic [NUM_CH-1:0]       ch_active,
  input  logic [NUM_CH-1:0]       half_clr,
  input  logic [NUM_CH-1:0]       done_clr,
  output logic [NUM_CH*CNT_W-1:0] citer_o,
  output logic [NUM_CH-1:0]       svc_req,
  output logic [NUM_CH-1:0]       half_irq,
  output logic [NUM_CH-1:0]       done_irq
);

  logic [NUM_CH-1:0] load_vec;
  logic [NUM_CH-1:0] start_vec;
  iter_evt_t         evt_vec [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign load_vec[g]  = cfg_we && (cfg_ch == CH_W'(g));
    assign start_vec[g] = sw_start_we && (sw_start_ch == CH_W'(g));

    dml_iter_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_vec[g]),
      .load_val (cfg_iter),
      .load_hen (cfg_half_en),
      .load_den (cfg_done_en),
      .step     (minor_done[g]),
      .citer    (citer_o[g*CNT_W +: CNT_W]),
      .evt      (evt_vec[g])
    );

    dml_w1c_flag u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt_vec[g].half_hit),
      .clr   (half_clr[g]),
      .q     (half_irq[g])
    );

    dml_w1c_flag u_done (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt_vec[g].major_hit),
      .clr   (done_clr[g]),
      .q     (done_irq[g])
    );

    dml_start_bit u_start (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_set     (start_vec[g]),
      .begin_exec (ch_active[g]),
      .req        (svc_req[g])
    );

    p_idle_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_vec[g] && !minor_done[g]) |=>
        $stable(citer_o[g*CNT_W +: CNT_W]));
  end

endmodule

// File: tb/dml_major_loop_tb.sv
`timescale 1ns/1ps
module dml_major_loop_tb;
  localparam int N  = 4;
  localparam int W  = 15;
  localparam int CW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n;
  logic           cfg_we;
  logic [CW-1:0]  cfg_ch;
  logic [W-1:0]   cfg_iter;
  logic           cfg_half_en, cfg_done_en;
  logic           sw_start_we;
  logic [CW-1:0]  sw_start_ch;
  logic [N-1:0]   minor_done, ch_active, half_clr, done_clr;
  logic [N*W-1:0] citer_o;
  logic [N-1:0]   svc_req, half_irq, done_irq;

  dml_major_loop #(.NUM_CH(N), .CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_iter(cfg_iter), .cfg_half_en(cfg_half_en), .cfg_done_en(cfg_done_en),
    .sw_start_we(sw_start_we), .sw_start_ch(sw_start_ch),
    .minor_done(minor_done), .ch_active(ch_active),
    .half_clr(half_clr), .done_clr(done_clr),
    .citer_o(citer_o), .svc_req(svc_req), .half_irq(half_irq), .done_irq(done_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_biter[N];
  int m_citer[N];
  bit m_hen[N], m_den[N], m_half[N], m_done[N], m_start[N];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      m_biter[c] = 0; m_citer[c] = 1;
      m_hen[c] = 0; m_den[c] = 0;
      m_half[c] = 0; m_done[c] = 0; m_start[c] = 0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < N; c++) begin
      bit hev = 0, dev = 0;
      int eff = (m_biter[c] == 0) ? 1 : m_biter[c];
      if (cfg_we && cfg_ch == c) begin
        m_biter[c] = cfg_iter;
        m_citer[c] = (cfg_iter == 0) ? 1 : cfg_iter;
        m_hen[c] = cfg_half_en;
        m_den[c] = cfg_done_en;
      end else if (minor_done[c]) begin
        int n = m_citer[c] - 1;
        if (n == 0) begin
          m_citer[c] = eff;
          dev = m_den[c];
        end else begin
          m_citer[c] = n;
        end
        hev = m_hen[c] && (eff >= 2) && (n == eff / 2);
      end
      if (hev) m_half[c] = 1; else if (half_clr[c]) m_half[c] = 0;
      if (dev) m_done[c] = 1; else if (done_clr[c]) m_done[c] = 0;
      if (sw_start_we && sw_start_ch == c) m_start[c] = 1;
      else if (ch_active[c]) m_start[c] = 0;
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < N; c++) begin
      chk($sformatf("R3 R4 R10 citer ch%0d", c), int'(citer_o[c*W +: W]), m_citer[c]);
      chk($sformatf("R5 R8 done ch%0d", c), int'(done_irq[c]), int'(m_done[c]));
      chk($sformatf("R6 R7 R8 half ch%0d", c), int'(half_irq[c]), int'(m_half[c]));
      chk($sformatf("R9 svc ch%0d", c), int'(svc_req[c]), int'(m_start[c]));
    end
  endtask

  task automatic clear_in();
    cfg_we = 0; cfg_ch = '0; cfg_iter = '0; cfg_half_en = 0; cfg_done_en = 0;
    sw_start_we = 0; sw_start_ch = '0;
    minor_done = '0; ch_active = '0; half_clr = '0; done_clr = '0;
  endtask

  // Inputs are set at a negedge; the model advances at the posedge; compare at the next negedge.
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    clear_in();
  endtask

  task automatic cfg(input int ch, input int it, input bit he, input bit de);
    cfg_we = 1; cfg_ch = CW'(ch); cfg_iter = W'(it); cfg_half_en = he; cfg_done_en = de;
    tick();
  endtask

  task automatic steps(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      minor_done[ch] = 1'b1;
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int c = 0; c < N; c++) begin
      chk("R1 reset citer", int'(citer_o[c*W +: W]), 1);
      chk("R1 reset flags", int'({half_irq[c], done_irq[c], svc_req[c]}), 0);
    end
    rst_n = 1;
    tick();

    // R2 R3 R5 R6: beginning count 4, midpoint 2
    cfg(0, 4, 1, 1);
    chk("R2 load citer", int'(citer_o[0 +: W]), 4);
    steps(0, 2);
    chk("R6 midpoint flag", int'(half_irq[0]), 1);
    steps(0, 2);
    chk("R4 reload to 4", int'(citer_o[0 +: W]), 4);
    chk("R5 end flag", int'(done_irq[0]), 1);
    // R8: set and clear together leave flag set
    half_clr[0] = 1; done_clr[0] = 1; tick();
    chk("R8 clear", int'({half_irq[0], done_irq[0]}), 0);
    steps(0, 1);
    half_clr[0] = 1; minor_done[0] = 1; tick();
    chk("R8 set beats clear", int'(half_irq[0]), 1);
    steps(0, 6);

    // R7: beginning count 1 never flags the midpoint
    cfg(1, 1, 1, 1);
    steps(1, 3);
    chk("R7 no midpoint for 1", int'(half_irq[1]), 0);
    // R4: beginning count 0 acts as 1
    cfg(2, 0, 1, 1);
    chk("R2 zero loads as one", int'(citer_o[2*W +: W]), 1);
    steps(2, 2);
    chk("R7 no midpoint for 0", int'(half_irq[2]), 0);
    // beginning count 2 and odd count 7
    cfg(3, 2, 1, 1);
    steps(3, 1);
    chk("R6 midpoint for 2", int'(half_irq[3]), 1);
    cfg(3, 7, 1, 0);
    steps(3, 10);
    // R2: write and step same cycle, write wins
    cfg_we = 1; cfg_ch = 2'd1; cfg_iter = W'(9); cfg_half_en = 1; cfg_done_en = 1;
    minor_done[1] = 1; tick();
    chk("R2 write beats step", int'(citer_o[W +: W]), 9);

    // R9: start, activation, and collision
    sw_start_we = 1; sw_start_ch = 2'd2; tick();
    chk("R9 start raises request", int'(svc_req[2]), 1);
    ch_active[2] = 1; tick();
    chk("R9 activation clears", int'(svc_req[2]), 0);
    sw_start_we = 1; sw_start_ch = 2'd2; ch_active[2] = 1; tick();
    chk("R9 start beats activation", int'(svc_req[2]), 1);

    // R10: random mix on all channels
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        cfg_we = 1; cfg_ch = CW'($urandom_range(0, N-1));
        cfg_iter = W'($urandom_range(0, 9));
        cfg_half_en = 1'($urandom_range(0, 1)); cfg_done_en = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 7) == 0) begin
        sw_start_we = 1; sw_start_ch = CW'($urandom_range(0, N-1));
      end
      minor_done = N'($urandom_range(0, (1 << N) - 1));
      ch_active  = N'($urandom_range(0, (1 << N) - 1)) & N'($urandom_range(0, (1 << N) - 1));
      half_clr   = ($urandom_range(0, 3) == 0) ? N'($urandom_range(0, (1 << N) - 1)) : '0;
      done_clr   = ($urandom_range(0, 3) == 0) ? N'($urandom_range(0, (1 << N) - 1)) : '0;
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule